// File: doc/BRIEF.md
# Range Clean-and-Invalidate Engine

This block sits next to one slice of a coherency directory and empties a physical address range out of it on request. Software programs a 64-bit start address and a byte span through split 32-bit registers, then writes a control word that names the operation. The engine walks the range one 128-byte line at a time and looks each line up in a small tag directory. A line the slice does not hold is skipped at no cost. A clean hit is invalidated at once. A dirty hit first raises a write-back request, which must be accepted, and is then invalidated.

Several such slices can share one address space, each holding an interleaved share of the lines. Each slice therefore treats a range outside its own lines as a silent no-op, and software may broadcast the same request to every slice. A status register shows whether a walk is in progress and holds a sticky error flag for requests with an unsupported operation code. A fill port records lines the slice starts tracking. A probe port reports whether a given line is present, and whether it is dirty.

Top module: `range_maint_engine`

## Requirements
- R1: After reset the engine is idle (`busy` = 0), every register reads 0, `wb_valid` is 0 and the directory holds no line.
- R2: Register indices 0, 1, 2 and 3 hold the start address bits 31:0, start bits 63:32, span bits 31:0 and span bits 63:32, and read back what was last written to them. The span is the byte count minus one.
- R3: A write to the control register (index 4) while idle, with bit 0 (enable) = 1 and bits 7:4 (operation) = 1, starts a walk. From the next cycle `busy`, control bit 0 and status (index 5) bit 0 read 1, and they clear by themselves once the walk ends.
- R4: With control bit 1 (range) = 1, the walk covers every line from floor(start/128) to floor((start+span)/128), both ends included. Lines outside that set are left untouched. Each line takes exactly one cycle unless a write-back is pending.
- R5: A walked line that misses causes no action. A walked line that hits clean is invalidated without a write-back.
- R6: A walked line that hits dirty drives `wb_valid` = 1 with `wb_line` = that line address. Both hold steady until `wb_ready` is 1. The entry is invalidated in the accepting cycle, and the walk then moves on.
- R7: A control write while busy is ignored. The walk in progress keeps its original range, and lines outside it stay present.
- R8: An enabled control write while idle with an operation other than 1 raises no busy and leaves the directory unchanged. It sets status bit 1 (error), which stays set until status is written with bit 1 = 1.
- R9: With control bit 1 = 0, only the single line that holds the start address is walked, whatever the span.
- R10: A fill installs its line with the given dirty flag in a free entry. A fill to a line already present ORs in the dirty flag. A fill is dropped when all 16 entries are taken or while busy.
- R11: The probe port reports, in the same cycle, whether `probe_line` is present and whether that entry is dirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_idx | input | 3 | Register index for the write |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_idx | input | 3 | Register index for the read |
| reg_rd_data | output | 32 | Read data, combinational from `reg_rd_idx` |
| track_valid | input | 1 | Fill request |
| track_line | input | 57 | Line address (byte address / 128) to track |
| track_dirty | input | 1 | Dirty flag of the filled line |
| probe_line | input | 57 | Line address to probe |
| probe_hit | output | 1 | Probed line is present |
| probe_dirty | output | 1 | Probed line is present and dirty |
| wb_valid | output | 1 | Write-back request valid |
| wb_ready | input | 1 | Write-back request accepted |
| wb_line | output | 57 | Line address to write back |
| busy | output | 1 | A walk is in progress |

## Verification
A start takes effect one clock after the control write: `busy` and the read-back bits change after that edge. A clean or missing line then retires on each following edge, and a dirty line retires on the edge where `wb_ready` is high. Register and probe reads are combinational and are due in the same cycle as their index. The bench keeps a behavioural model that takes each rising edge as one step. It compares `busy`, the write-back request, the selected register and the probe result against that model shortly after every falling edge, so each expected value is taken a full half period away from the edge that produces it. Directed scenarios also check the directory contents once each walk ends, the exact length of a walk over missing lines, and the order of write-back requests under a stalling `wb_ready`.

// File: rtl/rme_pkg.sv
package rme_pkg;
    localparam int ADDR_W     = 64;
    localparam int LINE_BYTES = 128;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int LINE_W     = ADDR_W - OFF_W;
    localparam int REG_W      = 32;
    localparam int REGIDX_W   = 3;
    localparam int OP_W       = 4;

    localparam logic [REGIDX_W-1:0] RIDX_START_LO = 3'd0;
    localparam logic [REGIDX_W-1:0] RIDX_START_HI = 3'd1;
    localparam logic [REGIDX_W-1:0] RIDX_SPAN_LO  = 3'd2;
    localparam logic [REGIDX_W-1:0] RIDX_SPAN_HI  = 3'd3;
    localparam logic [REGIDX_W-1:0] RIDX_CTRL     = 3'd4;
    localparam logic [REGIDX_W-1:0] RIDX_STATUS   = 3'd5;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_RANGE_BIT = 1;
    localparam int CTRL_OP_LSB    = 4;
    localparam int STAT_BUSY_BIT  = 0;
    localparam int STAT_ERR_BIT   = 1;

    localparam logic [OP_W-1:0] OP_CLEAN_INV = 4'd1;

    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_SCAN  = 2'd1,
        WK_FLUSH = 2'd2
    } walk_state_e;
endpackage

// File: rtl/maint_regs.sv
module maint_regs
    import rme_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REGIDX_W-1:0] wr_idx,
    input  logic [REG_W-1:0]    wr_data,
    input  logic [REGIDX_W-1:0] rd_idx,
    output logic [REG_W-1:0]    rd_data,
    input  logic                busy_i,
    output logic [ADDR_W-1:0]   start_addr_o,
    output logic [ADDR_W-1:0]   span_o,
    output logic                range_o,
    output logic                go_o,
    output logic                bad_o
);
    typedef struct packed {
        logic [REG_W-1:0] start_lo;
        logic [REG_W-1:0] start_hi;
        logic [REG_W-1:0] span_lo;
        logic [REG_W-1:0] span_hi;
        logic             err;
    } regs_t;

    regs_t r_d, r_q;
    logic  ctrl_hit;
    logic [OP_W-1:0] op_code;

    assign op_code = wr_data[CTRL_OP_LSB +: OP_W];
    assign range_o = wr_data[CTRL_RANGE_BIT];

    always_comb begin
        r_d      = r_q;
        go_o     = 1'b0;
        bad_o    = 1'b0;
        ctrl_hit = wr_en && (wr_idx == RIDX_CTRL) && wr_data[CTRL_EN_BIT] && !busy_i;
        if (ctrl_hit) begin
            if (op_code == OP_CLEAN_INV) begin
                go_o = 1'b1;
            end else begin
                bad_o = 1'b1;
                r_d.err = 1'b1;
            end
        end
        if (wr_en) begin
            case (wr_idx)
                RIDX_START_LO: r_d.start_lo = wr_data;
                RIDX_START_HI: r_d.start_hi = wr_data;
                RIDX_SPAN_LO:  r_d.span_lo  = wr_data;
                RIDX_SPAN_HI:  r_d.span_hi  = wr_data;
                RIDX_STATUS:   if (wr_data[STAT_ERR_BIT]) r_d.err = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign start_addr_o = {r_q.start_hi, r_q.start_lo};
    assign span_o       = {r_q.span_hi, r_q.span_lo};

    always_comb begin
        rd_data = '0;
        case (rd_idx)
            RIDX_START_LO: rd_data = r_q.start_lo;
            RIDX_START_HI: rd_data = r_q.start_hi;
            RIDX_SPAN_LO:  rd_data = r_q.span_lo;
            RIDX_SPAN_HI:  rd_data = r_q.span_hi;
            RIDX_CTRL:     rd_data[CTRL_EN_BIT] = busy_i;
            RIDX_STATUS: begin
                rd_data[STAT_BUSY_BIT] = busy_i;
                rd_data[STAT_ERR_BIT]  = r_q.err;
            end
            default: ;
        endcase
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.err && !(wr_en && wr_idx == RIDX_STATUS && wr_data[STAT_ERR_BIT]) |=> r_q.err); // R8
endmodule

// File: rtl/line_directory.sv
module line_directory
    import rme_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int LW      = LINE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_valid,
    input  logic [LW-1:0]      fill_line,
    input  logic               fill_dirty,
    input  logic               fill_block,
    input  logic [LW-1:0]      walk_line,
    output logic [ENTRIES-1:0] walk_hit_vec,
    output logic               walk_dirty_hit,
    input  logic               inv_en,
    input  logic [ENTRIES-1:0] inv_vec,
    input  logic [LW-1:0]      q_line,
    output logic               q_hit,
    output logic               q_dirty
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0] v;
        logic [ENTRIES-1:0] d;
    } flags_t;

    flags_t             flags_d, flags_q;
    logic [LW-1:0]      tag_d [ENTRIES];
    logic [LW-1:0]      tag_q [ENTRIES];
    logic [ENTRIES-1:0] fill_hit_vec;
    logic [ENTRIES-1:0] q_hit_vec;
    logic               free_found;
    logic [IDX_W-1:0]   free_idx;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cam
        assign walk_hit_vec[g] = flags_q.v[g] && (tag_q[g] == walk_line);
        assign fill_hit_vec[g] = flags_q.v[g] && (tag_q[g] == fill_line);
        assign q_hit_vec[g]    = flags_q.v[g] && (tag_q[g] == q_line);
    end

    assign walk_dirty_hit = |(walk_hit_vec & flags_q.d);
    assign q_hit          = |q_hit_vec;
    assign q_dirty        = |(q_hit_vec & flags_q.d);

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!flags_q.v[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    always_comb begin
        flags_d = flags_q;
        for (int i = 0; i < ENTRIES; i++) tag_d[i] = tag_q[i];
        if (inv_en) begin
            flags_d.v = flags_q.v & ~inv_vec;
            flags_d.d = flags_q.d & ~inv_vec;
        end
        if (fill_valid && !fill_block) begin
            if (|fill_hit_vec) begin
                flags_d.d = flags_d.d | (fill_hit_vec & {ENTRIES{fill_dirty}});
            end else if (free_found) begin
                flags_d.v[free_idx] = 1'b1;
                flags_d.d[free_idx] = fill_dirty;
                tag_d[free_idx]     = fill_line;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            for (int i = 0; i < ENTRIES; i++) tag_q[i] <= '0;
        end else begin
            flags_q <= flags_d;
            for (int i = 0; i < ENTRIES; i++) tag_q[i] <= tag_d[i];
        end
    end

    AST_INV_ONE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        inv_en |-> $countones(inv_vec) == 1); // R5
    AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        inv_en |=> (flags_q.v & $past(inv_vec)) == '0); // R5
    AST_FILL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid && fill_block && !inv_en |=> $stable(flags_q)); // R10
endmodule

// File: rtl/range_walker.sv
module range_walker
    import rme_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [ADDR_W-1:0] span_i,
    input  logic              range_i,
    input  logic              hit_any_i,
    input  logic              dirty_hit_i,
    input  logic              wb_ready_i,
    output logic              busy_o,
    output logic [LINE_W-1:0] walk_line_o,
    output logic              inv_en_o,
    output logic              wb_valid_o,
    output logic [LINE_W-1:0] wb_line_o
);
    typedef struct packed {
        walk_state_e       st;
        logic [LINE_W-1:0] cur;
        logic [LINE_W-1:0] last;
    } walk_t;

    walk_t             w_d, w_q;
    logic              advance;
    logic [ADDR_W-1:0] end_addr;
    logic              unused_low;

    assign end_addr   = range_i ? (start_addr_i + span_i) : start_addr_i;
    assign unused_low = ^{end_addr[OFF_W-1:0], start_addr_i[OFF_W-1:0]};

    always_comb begin
        w_d      = w_q;
        inv_en_o = 1'b0;
        advance  = 1'b0;
        case (w_q.st)
            WK_IDLE: begin
                if (go_i) begin
                    w_d.st   = WK_SCAN;
                    w_d.cur  = start_addr_i[ADDR_W-1:OFF_W];
                    w_d.last = end_addr[ADDR_W-1:OFF_W];
                end
            end
            WK_SCAN: begin
                if (hit_any_i && dirty_hit_i) begin
                    w_d.st = WK_FLUSH;
                end else begin
                    inv_en_o = hit_any_i;
                    advance  = 1'b1;
                end
            end
            WK_FLUSH: begin
                if (wb_ready_i) begin
                    inv_en_o = 1'b1;
                    advance  = 1'b1;
                end
            end
            default: w_d.st = WK_IDLE;
        endcase
        if (advance) begin
            if (w_q.cur == w_q.last) begin
                w_d.st = WK_IDLE;
            end else begin
                w_d.st  = WK_SCAN;
                w_d.cur = w_q.cur + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '{st: WK_IDLE, cur: '0, last: '0};
        else        w_q <= w_d;
    end

    assign busy_o      = (w_q.st != WK_IDLE);
    assign wb_valid_o  = (w_q.st == WK_FLUSH);
    assign wb_line_o   = w_q.cur;
    assign walk_line_o = w_q.cur;

    AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o && !wb_ready_i |=> wb_valid_o && $stable(wb_line_o)); // R6
    AST_GO_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> !busy_o); // R7
    AST_GO_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |=> busy_o); // R3
endmodule

// File: rtl/range_maint_engine.sv
module range_maint_engine
    import rme_pkg::*;
#(
    parameter int DIR_ENTRIES = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic [REGIDX_W-1:0] reg_wr_idx,
    input  logic [REG_W-1:0]    reg_wr_data,
    input  logic [REGIDX_W-1:0] reg_rd_idx,
    output logic [REG_W-1:0]    reg_rd_data,
    input  logic                track_valid,
    input  logic [LINE_W-1:0]   track_line,
    input  logic                track_dirty,
    input  logic [LINE_W-1:0]   probe_line,
    output logic                probe_hit,
    output logic                probe_dirty,
    output logic                wb_valid,
    input  logic                wb_ready,
    output logic [LINE_W-1:0]   wb_line,
    output logic                busy
);
    logic [ADDR_W-1:0]      start_addr, span;
    logic                   range_mode, go, bad;
    logic [LINE_W-1:0]      walk_line;
    logic [DIR_ENTRIES-1:0] walk_hit_vec;
    logic                   walk_dirty_hit, inv_en;

    maint_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (reg_wr_en),
        .wr_idx       (reg_wr_idx),
        .wr_data      (reg_wr_data),
        .rd_idx       (reg_rd_idx),
        .rd_data      (reg_rd_data),
        .busy_i       (busy),
        .start_addr_o (start_addr),
        .span_o       (span),
        .range_o      (range_mode),
        .go_o         (go),
        .bad_o        (bad)
    );

    range_walker u_walker (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_i         (go),
        .start_addr_i (start_addr),
        .span_i       (span),
        .range_i      (range_mode),
        .hit_any_i    (|walk_hit_vec),
        .dirty_hit_i  (walk_dirty_hit),
        .wb_ready_i   (wb_ready),
        .busy_o       (busy),
        .walk_line_o  (walk_line),
        .inv_en_o     (inv_en),
        .wb_valid_o   (wb_valid),
        .wb_line_o    (wb_line)
    );

    line_directory #(.ENTRIES(DIR_ENTRIES), .LW(LINE_W)) u_dir (
        .clk            (clk),
        .rst_n          (rst_n),
        .fill_valid     (track_valid),
        .fill_line      (track_line),
        .fill_dirty     (track_dirty),
        .fill_block     (busy),
        .walk_line      (walk_line),
        .walk_hit_vec   (walk_hit_vec),
        .walk_dirty_hit (walk_dirty_hit),
        .inv_en         (inv_en),
        .inv_vec        (walk_hit_vec),
        .q_line         (probe_line),
        .q_hit          (probe_hit),
        .q_dirty        (probe_dirty)
    );

    AST_BAD_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> !busy); // R8
    AST_WB_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> busy); // R6
    AST_INV_NEEDS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        inv_en |-> busy && (|walk_hit_vec)); // R5
endmodule

// File: tb/range_maint_engine_bench.sv
module range_maint_engine_bench;
    localparam int LW = 57;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [2:0]    reg_wr_idx = '0;
    logic [31:0]   reg_wr_data = '0;
    logic [2:0]    reg_rd_idx = 3'd5;
    logic [31:0]   reg_rd_data;
    logic          track_valid = 1'b0;
    logic [LW-1:0] track_line = '0;
    logic          track_dirty = 1'b0;
    logic [LW-1:0] probe_line = '0;
    logic          probe_hit, probe_dirty;
    logic          wb_valid;
    logic          wb_ready = 1'b1;
    logic [LW-1:0] wb_line;
    logic          busy;

    range_maint_engine u_range_maint_engine (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data),
        .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data),
        .track_valid(track_valid), .track_line(track_line), .track_dirty(track_dirty),
        .probe_line(probe_line), .probe_hit(probe_hit), .probe_dirty(probe_dirty),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_line(wb_line), .busy(busy)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int cyc = 0;
    bit rdy_slow = 0;

    // behavioural reference state
    bit                m_dir [longint unsigned];
    longint unsigned   m_start, m_len, m_cur, m_end;
    bit                m_busy, m_wb, m_err;
    longint unsigned   wb_seen [$];

    task automatic chk(input bit ok, input string tag, input longint unsigned act,
                       input longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model, one step per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir.delete();
            m_start = 0; m_len = 0; m_cur = 0; m_end = 0;
            m_busy = 0; m_wb = 0; m_err = 0;
        end else begin
            bit pb;
            pb = m_busy;
            if (pb) begin
                bit adv;
                adv = 0;
                if (m_wb) begin
                    if (wb_ready) begin
                        m_dir.delete(m_cur);
                        adv = 1;
                    end
                end else if (m_dir.exists(m_cur) && m_dir[m_cur]) begin
                    m_wb = 1;
                end else begin
                    if (m_dir.exists(m_cur)) m_dir.delete(m_cur);
                    adv = 1;
                end
                if (adv) begin
                    m_wb = 0;
                    if (m_cur == m_end) m_busy = 0;
                    else m_cur = m_cur + 1;
                end
            end
            if (track_valid && !pb) begin
                longint unsigned k;
                k = longint'(track_line);
                if (m_dir.exists(k)) m_dir[k] = m_dir[k] | track_dirty;
                else if (m_dir.size() < 16) m_dir[k] = track_dirty;
            end
            if (reg_wr_en) begin
                case (reg_wr_idx)
                    3'd0: m_start[31:0]  = reg_wr_data;
                    3'd1: m_start[63:32] = reg_wr_data;
                    3'd2: m_len[31:0]    = reg_wr_data;
                    3'd3: m_len[63:32]   = reg_wr_data;
                    3'd4: if (reg_wr_data[0] && !pb) begin
                        if (reg_wr_data[7:4] == 4'd1) begin
                            m_busy = 1; m_wb = 0;
                            m_cur = m_start >> 7;
                            m_end = (reg_wr_data[1] ? (m_start + m_len) : m_start) >> 7;
                        end else begin
                            m_err = 1;
                        end
                    end
                    3'd5: if (reg_wr_data[1]) m_err = 0;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] exp_rd(input logic [2:0] idx);
        case (idx)
            3'd0: return m_start[31:0];
            3'd1: return m_start[63:32];
            3'd2: return m_len[31:0];
            3'd3: return m_len[63:32];
            3'd4: return {31'd0, m_busy};
            3'd5: return {30'd0, m_err, m_busy};
            default: return 32'd0;
        endcase
    endfunction

    // per-cycle comparison, half a period away from the rising edge
    always @(negedge clk) begin
        cyc++;
        wb_ready <= !rdy_slow || (cyc % 3 == 2);
        #1;
        if (rst_n && !finished) begin
            longint unsigned pk;
            pk = longint'(probe_line);
            chk(busy === m_busy, "R3 busy", busy, m_busy);
            chk(wb_valid === (m_busy && m_wb), "R6 wb_valid", wb_valid, m_busy && m_wb);
            if (wb_valid) chk(longint'(wb_line) == m_cur, "R6 wb_line", wb_line, m_cur);
            chk(reg_rd_data === exp_rd(reg_rd_idx), "R2 reg_rd_data", reg_rd_data, exp_rd(reg_rd_idx));
            chk(probe_hit === m_dir.exists(pk), "R11 probe_hit", probe_hit, m_dir.exists(pk));
            if (m_dir.exists(pk))
                chk(probe_dirty === m_dir[pk], "R11 probe_dirty", probe_dirty, m_dir[pk]);
            if (wb_valid && wb_ready) wb_seen.push_back(longint'(wb_line));
        end
    end

    task automatic reg_wr(input logic [2:0] idx, input logic [31:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_idx = idx; reg_wr_data = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic fill(input longint unsigned line, input bit dirty);
        @(negedge clk);
        track_valid = 1'b1; track_line = LW'(line); track_dirty = dirty;
        @(negedge clk);
        track_valid = 1'b0;
    endtask

    task automatic set_range(input longint unsigned start, input longint unsigned span);
        reg_wr(3'd0, start[31:0]);
        reg_wr(3'd1, start[63:32]);
        reg_wr(3'd2, span[31:0]);
        reg_wr(3'd3, span[63:32]);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        #1;
        while (busy && n < 5000) begin
            n++;
            @(negedge clk); #1;
        end
    endtask

    task automatic probe(input longint unsigned line, input bit present, input string tag);
        @(negedge clk);
        probe_line = LW'(line);
        #1;
        chk(probe_hit === present, tag, probe_hit, present);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1: reset state
        chk(busy === 1'b0, "R1 busy after reset", busy, 0);
        chk(reg_rd_data === 32'd0, "R1 status after reset", reg_rd_data, 0);
        chk(probe_hit === 1'b0, "R1 directory empty", probe_hit, 0);

        // R2: split register readback
        set_range(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); reg_rd_idx = 3'(i); #1;
            chk(reg_rd_data === exp_rd(3'(i)), "R2 readback", reg_rd_data, exp_rd(3'(i)));
        end

        // R10: fills and dirty merge
        fill(64'h10, 0); fill(64'h11, 1); fill(64'h13, 0);
        fill(64'h0F, 0); fill(64'h14, 1);
        fill(64'h12, 0); fill(64'h12, 1);
        @(negedge clk); probe_line = LW'(64'h12); #1;
        chk(probe_dirty === 1'b1, "R10 dirty merge", probe_dirty, 1);

        // R3/R4/R5/R6: inclusive range 0x805..0x980 covers lines 0x10..0x13
        set_range(64'h805, 64'h17B);
        rdy_slow = 1;
        wb_seen.delete();
        reg_rd_idx = 3'd4;
        reg_wr(3'd4, 32'h13);
        #1;
        chk(reg_rd_data[0] === 1'b1, "R3 control enable reads back", reg_rd_data, 1);
        wait_idle(n);
        rdy_slow = 0;
        chk(reg_rd_data[0] === 1'b0, "R3 enable self-clears", reg_rd_data, 0);
        reg_rd_idx = 3'd5;
        probe(64'h10, 0, "R5 clean hit invalidated");
        probe(64'h13, 0, "R4 last partial line walked");
        probe(64'h11, 0, "R6 dirty line invalidated");
        probe(64'h0F, 1, "R4 line below range kept");
        probe(64'h14, 1, "R4 line above range kept");
        chk(wb_seen.size() == 2, "R6 write-back count", wb_seen.size(), 2);
        if (wb_seen.size() == 2) begin
            chk(wb_seen[0] == 64'h11, "R6 first write-back", wb_seen[0], 64'h11);
            chk(wb_seen[1] == 64'h12, "R6 second write-back", wb_seen[1], 64'h12);
        end

        // R7 and R10 (fill while busy)
        fill(64'h300, 0);
        set_range(64'h100 * 128, 16 * 128 - 1);
        reg_wr(3'd4, 32'h13);
        reg_wr(3'd0, 32'h18000);
        reg_wr(3'd4, 32'h13);
        fill(64'h700, 0);
        wait_idle(n);
        probe(64'h300, 1, "R7 start while busy ignored");
        probe(64'h700, 0, "R10 fill while busy dropped");

        // R8: unsupported operation
        fill(64'h40, 0);
        set_range(64'h40 * 128, 0);
        reg_wr(3'd4, 32'h21);
        #1;
        chk(busy === 1'b0, "R8 no busy on bad op", busy, 0);
        chk(reg_rd_data[1] === 1'b1, "R8 error set", reg_rd_data, 2);
        probe(64'h40, 1, "R8 directory unchanged");
        reg_wr(3'd5, 32'h2);
        #1;
        chk(reg_rd_data[1] === 1'b0, "R8 error cleared", reg_rd_data, 0);

        // R9: single-line mode
        fill(64'h20, 0); fill(64'h21, 0);
        set_range(64'h20 * 128, 200);
        reg_wr(3'd4, 32'h11);
        wait_idle(n);
        chk(n == 1, "R9 one line walked", n, 1);
        probe(64'h20, 0, "R9 start line invalidated");
        probe(64'h21, 1, "R9 next line untouched");

        // R10: full directory drops new fills
        for (int i = 0; i < 11; i++) fill(64'h500 + i, 0);
        fill(64'h600, 1);
        probe(64'h50A, 1, "R10 sixteenth entry installed");
        probe(64'h600, 0, "R10 fill dropped when full");

        // R4/R5: range of missing lines takes one cycle per line
        set_range(64'h900 * 128, 4 * 128 - 1);
        reg_wr(3'd4, 32'h13);
        wait_idle(n);
        chk(n == 4, "R4 miss-only walk length", n, 4);
        probe(64'h0F, 1, "R5 miss range left directory intact");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule